// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a reference clock-enable into a slower tick for serial channels. A 32-bit control word holds a 12-bit divisor, a divide-by-16 prescaler select and a run enable. While the generator runs, it emits a one-cycle `tick` once every (divisor field + 1) prescaled reference pulses. It also drives a square wave that changes level on every tick.

The divisor is stored as the wanted ratio minus one, in bits 12:1 of the control word. Software therefore writes (ratio − 1) shifted left by one. The prescaler is meant for ratios larger than 4096, which the 12-bit counter cannot reach alone. A receiver that oversamples by 16 treats each tick as one sixteenth of a bit time. A system holds several independent copies of this block.

Any write to the control word restarts the count at the next reference pulse, so no period mixes the old and new settings.

Top module: `baud_gen`

## Requirements
- R1: `cfg_rdata` returns the stored divisor in bits 12:1, the prescaler select in bit 13 and the enable in bit 16. Every other bit, bit 0 included, reads as zero whatever was written.
- R2: After reset, `cfg_rdata`, `tick` and `sq_out` are all zero.
- R3: While the enable bit (bit 16) is clear, `tick` and `sq_out` stay low.
- R4: With the prescaler off and the generator running, `tick` pulses for one cycle once every (D+1) reference pulses, where D is the divisor field. The pulse appears in the cycle after the reference pulse that completes the period.
- R5: With the prescaler bit (bit 13) set, the tick period is 16·(D+1) reference pulses.
- R6: After a write, the first reference pulse reloads the counter and produces no tick. The first tick then follows a full new period counted from that reload pulse.
- R7: `sq_out` toggles in exactly the cycles in which `tick` is high.
- R8: Cycles without a reference pulse neither advance the count nor produce a tick.
- R9: With D = 0 and the prescaler off, `tick` follows every reference pulse, one cycle later.
- R10: With D = 4095 and the prescaler off, the period is 4096 reference pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we | input | 1 | control word write strobe |
| cfg_wdata | input | 32 | control word to write |
| cfg_rdata | output | 32 | stored control word |
| ref_en | input | 1 | reference clock-enable pulse |
| tick | output | 1 | one-cycle rate tick |
| sq_out | output | 1 | square wave, toggles per tick |

## Verification
A wrong counter or prescaler value shows as a tick that comes early or late. The error appears at the very next period boundary, at most 16·4096 reference pulses later. A stuck reload flag shows as a first period that is one pulse too long or too short, or as a tick in the reload cycle. A wrong square-wave state shows at once as an `sq_out` level that no longer matches the parity of ticks counted since enable.

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int CNT_W   = 12,
  parameter int PSC_DIV = 16,
  parameter int DIV_LSB = 1,
  parameter int PSC_BIT = 13,
  parameter int EN_BIT  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        ref_en,
  output logic        tick,
  output logic        sq_out
);
  localparam int PSC_W   = $clog2(PSC_DIV);
  localparam int DIV_MSB = DIV_LSB + CNT_W - 1;
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PSC_DIV - 1);

  logic [CNT_W-1:0] div_q, cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic             psc_on_q, en_q, pend_q, tick_q, sq_q;
  logic             stage;

  assign stage  = ref_en & (~psc_on_q | (psc_q == PSC_LAST));
  assign tick   = tick_q;
  assign sq_out = sq_q;

  always_comb begin
    cfg_rdata                  = '0;
    cfg_rdata[DIV_MSB:DIV_LSB] = div_q;
    cfg_rdata[PSC_BIT]         = psc_on_q;
    cfg_rdata[EN_BIT]          = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      psc_on_q <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      psc_q    <= '0;
      tick_q   <= 1'b0;
      sq_q     <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (cfg_we) begin
        div_q    <= cfg_wdata[DIV_MSB:DIV_LSB];
        psc_on_q <= cfg_wdata[PSC_BIT];
        en_q     <= cfg_wdata[EN_BIT];
        pend_q   <= 1'b1;
      end else if (en_q && ref_en && pend_q) begin
        pend_q <= 1'b0;
      end
      if (!en_q) begin
        cnt_q <= '0;
        psc_q <= '0;
        sq_q  <= 1'b0;
      end else if (ref_en) begin
        if (pend_q) begin
          cnt_q <= div_q;
          psc_q <= '0;
        end else begin
          if (psc_on_q)
            psc_q <= (psc_q == PSC_LAST) ? '0 : psc_q + 1'b1;
          if (stage) begin
            if (cnt_q == '0) begin
              tick_q <= 1'b1;
              sq_q   <= ~sq_q;
              cnt_q  <= div_q;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

module baud_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_rdata,
  input logic        ref_en,
  input logic        tick,
  input logic        sq_out
);
  // R1: undefined bits read zero
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~32'h0001_3FFE) == 32'h0);

  // R8: every tick follows a reference pulse
  p_tick_after_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(ref_en));

  // R3: no tick from a disabled generator
  p_tick_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(cfg_rdata[16]));

  // R7: square output moves only on a tick or when disabled
  p_sq_follows_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_out != $past(sq_out)) |-> (tick || !$past(cfg_rdata[16])));

  // R9: back-to-back ticks only with the shortest setting
  p_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick)) |-> ($past(cfg_rdata[12:1]) == 12'd0 && !$past(cfg_rdata[13])));
endmodule

bind baud_gen baud_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
  .ref_en(ref_en), .tick(tick), .sq_out(sq_out)
);

// File: tb/baud_gen_tb.sv
module baud_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ref_en = 1'b0;
  logic        tick, sq_out;

  int    errors = 0;
  int    checks = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R2";
  int    ref_mode = 0;
  int    ref_cnt = 0;

  int m_div = 0, m_phase = 0;
  bit m_psc = 0, m_en = 0, m_pend = 0;
  bit e_tick = 0, e_sq = 0;
  logic [31:0] e_rd = '0;

  baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ref_en(ref_en), .tick(tick), .sq_out(sq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word(int d, bit p, bit e);
    return (32'(d) << 1) | (32'(p) << 13) | (32'(e) << 16);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_psc = 0; m_en = 0; m_pend = 0; m_phase = 0;
      e_tick = 0; e_sq = 0; e_rd = '0;
    end else begin
      e_tick = 0;
      if (!m_en) begin
        m_phase = 0;
        e_sq = 0;
      end else if (ref_en) begin
        if (m_pend) begin
          m_phase = 0;
          m_pend = 0;
        end else begin
          m_phase++;
          if (m_phase % ((m_div + 1) * (m_psc ? 16 : 1)) == 0) begin
            e_tick = 1;
            e_sq = !e_sq;
          end
        end
      end
      if (cfg_we) begin
        m_div = int'(cfg_wdata[12:1]);
        m_psc = cfg_wdata[13];
        m_en = cfg_wdata[16];
        m_pend = 1;
        e_rd = cfg_wdata & 32'h0001_3FFE;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (tick !== e_tick) begin
        errors++;
        $display("FAIL %s tick: actual=%0b expected=%0b t=%0t", tag, tick, e_tick, $time);
      end
      checks++;
      if (sq_out !== e_sq) begin
        errors++;
        $display("FAIL R7 (sq during %s): actual=%0b expected=%0b t=%0t", tag, sq_out, e_sq, $time);
      end
      checks++;
      if (cfg_rdata !== e_rd) begin
        errors++;
        $display("FAIL R1 readback: actual=%h expected=%h", cfg_rdata, e_rd);
      end
    end
    ref_cnt++;
    case (ref_mode)
      0: ref_en <= 1'b0;
      1: ref_en <= 1'b1;
      2: ref_en <= (ref_cnt % 3 == 0);
      default: ref_en <= ((ref_cnt * 7) % 5) < 2;
    endcase
  end

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_we <= 1'b1;
    cfg_wdata <= w;
    @(negedge clk);
    cfg_we <= 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  initial begin
    run(3);
    check_eq("R2 rdata", cfg_rdata, 32'h0);
    check_eq("R2 tick", {31'd0, tick}, 32'h0);
    check_eq("R2 sq", {31'd0, sq_out}, 32'h0);
    rst_n = 1'b1;
    run(1);
    cmp_on = 1'b1;
    tag = "R1";
    wr(32'hFFFF_FFFF);
    run(1);
    check_eq("R1 mask", cfg_rdata, 32'h0001_3FFE);
    wr(32'h0);
    tag = "R3"; ref_mode = 1;
    wr(word(2, 0, 0) | 32'h1);
    run(50);
    tag = "R4";
    wr(word(4, 0, 1));
    run(100);
    tag = "R8"; ref_mode = 2;
    run(200);
    ref_mode = 3;
    run(200);
    tag = "R9"; ref_mode = 1;
    wr(word(0, 0, 1));
    run(50);
    tag = "R5";
    wr(word(3, 1, 1));
    run(300);
    ref_mode = 3;
    run(300);
    tag = "R6"; ref_mode = 1;
    wr(word(6, 0, 1));
    run(10);
    wr(word(2, 0, 1));
    run(40);
    wr(word(5, 1, 1));
    run(37);
    wr(word(1, 0, 1));
    run(40);
    tag = "R3";
    wr(word(1, 0, 0));
    run(40);
    tag = "R10";
    wr(word(4095, 0, 1));
    run(9000);
    tag = "R7";
    wr(word(7, 0, 1));
    run(100);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule